// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline

This block sits in the decode stage of an in-order pipeline. It watches the instruction held in the execute-stage pipeline register. If that instruction is a memory read and its destination register is one of the two source registers of the instruction now being decoded, the loaded value cannot be ready in time. The block then holds the program counter and the fetch/decode register for one cycle. It also writes all-zero control bits into the execute-stage register. The result is a single bubble: the dependent instruction is decoded a second time, and the instruction after it is fetched a second time.

So that the stall can be observed at the pins, the block carries its own small pipeline front. This front has a program counter that steps by four, a fetch/decode instruction register, a decoder with a fixed instruction format, and the control and destination fields of the execute-stage register. An external instruction memory returns the word addressed by `pc_o` in the same cycle. Operand forwarding and branch redirection are handled elsewhere.

The interlock keeps no counter. One cycle after the bubble, the load has moved past the execute stage, so the hazard condition clears without help.

Top module: `load_use_interlock`

## Requirements
- R1: While reset is asserted (`rst_n` low), and at the first sample after it, `pc_o` is 0, `ifid_instr_o` is 0, `idex_ctrl_o` is 0 and `bubble_o` is 0.
- R2: When `idex_ctrl_o[2]` (memory read) is 1 and `idex_rd_o` equals the first source field (bits [9:5]) of `ifid_instr_o`, `bubble_o` is 1 and `pc_we_o` and `ifid_we_o` are 0 in that same cycle.
- R3: The same stall occurs when `idex_rd_o` matches only the second source field (bits [14:10]) of `ifid_instr_o`.
- R4: When `idex_ctrl_o[2]` is 0, no stall occurs, even if the execute-stage instruction writes a register that the decoded instruction reads.
- R5: A memory read whose destination is register 31 (all ones) never causes a stall.
- R6: In the cycle after a stall, `pc_o` and `ifid_instr_o` are unchanged, so the dependent instruction is still in decode.
- R7: In the cycle after a stall, `idex_ctrl_o` is all zero (a no-operation).
- R8: A stall lasts exactly one cycle. One cycle later, the dependent instruction's own controls and destination appear in `idex_ctrl_o` and `idex_rd_o`, and `pc_o` advances again.
- R9: Without a stall, `pc_o` grows by 4 each cycle. The fetched word enters `ifid_instr_o`. The decoded controls enter `idex_ctrl_o` with this layout: bit 3 register write, bit 2 memory read, bit 1 memory write, bit 0 ALU use. The instruction format is class in bits [31:30] (00 no-op → 0000, 01 ALU → 1001, 10 load → 1100, 11 store → 0011) and destination in bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_word_i | input | 32 | Instruction word at address `pc_o`, returned in the same cycle |
| pc_o | output | 32 | Current fetch address |
| pc_we_o | output | 1 | Program counter update enable (0 during a stall) |
| ifid_we_o | output | 1 | Fetch/decode register update enable (0 during a stall) |
| bubble_o | output | 1 | Zero the controls written into the execute-stage register |
| ifid_instr_o | output | 32 | Instruction held in the decode stage |
| idex_ctrl_o | output | 4 | Execute-stage controls {reg write, mem read, mem write, ALU use} |
| idex_rd_o | output | 5 | Execute-stage destination register |

## Verification
The bench runs instruction pairs in which a load is followed by an instruction that reads the loaded register through its first field, through its second field, or not at all. A design that compared only one field would miss the second-field case. A design that ignored the memory-read flag would stall after a plain ALU write. A design that did not exempt register 31 would lose a cycle on loads to it. After each stall the bench checks that the address and the decode register held, that the execute stage saw a zero-control bubble, and that the dependent instruction then arrived with its own controls. A stall that lasted two cycles, or a bubble that kept the load's controls, would therefore be caught.

// File: rtl/lui_pkg.sv
package lui_pkg;

    // Instruction class carried in the two top bits of a word.
    typedef enum logic [1:0] {
        CLS_NOP   = 2'b00,
        CLS_ALU   = 2'b01,
        CLS_LOAD  = 2'b10,
        CLS_STORE = 2'b11
    } instr_cls_e;

    // Control bundle that travels in the execute-stage register.
    typedef struct packed {
        logic reg_wr;
        logic mem_rd;
        logic mem_wr;
        logic alu_use;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/lui_decode.sv
module lui_decode
    import lui_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [1:0]          cls_i,
    input  logic [3*REG_AW-1:0] fields_i,
    output ctrl_t               ctrl_o,
    output logic [REG_AW-1:0]   rd_o,
    output logic [REG_AW-1:0]   rn_o,
    output logic [REG_AW-1:0]   rm_o
);

    localparam int RD_LSB = 0;
    localparam int RN_LSB = REG_AW;
    localparam int RM_LSB = 2 * REG_AW;

    instr_cls_e cls;

    assign cls  = instr_cls_e'(cls_i);
    assign rd_o = fields_i[RD_LSB +: REG_AW];
    assign rn_o = fields_i[RN_LSB +: REG_AW];
    assign rm_o = fields_i[RM_LSB +: REG_AW];

    always_comb begin
        ctrl_o = '0;
        unique case (cls)
            CLS_ALU: begin
                ctrl_o.reg_wr  = 1'b1;
                ctrl_o.alu_use = 1'b1;
            end
            CLS_LOAD: begin
                ctrl_o.reg_wr = 1'b1;
                ctrl_o.mem_rd = 1'b1;
            end
            CLS_STORE: begin
                ctrl_o.mem_wr  = 1'b1;
                ctrl_o.alu_use = 1'b1;
            end
            default: ctrl_o = '0;
        endcase
    end

endmodule

// File: rtl/lui_hazard.sv
module lui_hazard #(
    parameter int REG_AW       = 5,
    parameter bit SKIP_TOP_REG = 1'b1
) (
    input  logic              ex_mem_rd_i,
    input  logic [REG_AW-1:0] ex_rd_i,
    input  logic [REG_AW-1:0] id_rn_i,
    input  logic [REG_AW-1:0] id_rm_i,
    output logic              pc_we_o,
    output logic              ifid_we_o,
    output logic              ctrl_zero_o
);

    localparam logic [REG_AW-1:0] TOP_REG = {REG_AW{1'b1}};

    logic rn_hit;
    logic rm_hit;
    logic dest_live;
    logic stall;

    assign rn_hit = (ex_rd_i == id_rn_i);
    assign rm_hit = (ex_rd_i == id_rm_i);

    generate
        if (SKIP_TOP_REG) begin : g_skip_top
            assign dest_live = (ex_rd_i != TOP_REG);
        end else begin : g_all_regs
            assign dest_live = 1'b1;
        end
    endgenerate

    assign stall       = ex_mem_rd_i && dest_live && (rn_hit || rm_hit);
    assign pc_we_o     = !stall;
    assign ifid_we_o   = !stall;
    assign ctrl_zero_o = stall;

endmodule

// File: rtl/lui_front.sv
module lui_front #(
    parameter int PC_W    = 32,
    parameter int INSTR_W = 32,
    parameter int PC_STEP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pc_we_i,
    input  logic               ifid_we_i,
    input  logic [INSTR_W-1:0] fetch_word_i,
    output logic [PC_W-1:0]    pc_o,
    output logic [INSTR_W-1:0] instr_o
);

    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    typedef struct packed {
        logic [PC_W-1:0]    pc;
        logic [INSTR_W-1:0] instr;
    } front_t;

    front_t st_d;
    front_t st_q;

    always_comb begin
        st_d = st_q;
        if (pc_we_i) begin
            st_d.pc = st_q.pc + STEP;
        end
        if (ifid_we_i) begin
            st_d.instr = fetch_word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o    = st_q.pc;
    assign instr_o = st_q.instr;

endmodule

// File: rtl/lui_idex.sv
module lui_idex
    import lui_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zero_ctrl_i,
    input  ctrl_t             ctrl_i,
    input  logic [REG_AW-1:0] rd_i,
    output ctrl_t             ctrl_o,
    output logic [REG_AW-1:0] rd_o
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [REG_AW-1:0] rd;
    } idex_t;

    idex_t st_d;
    idex_t st_q;

    always_comb begin
        st_d.rd   = rd_i;
        st_d.ctrl = zero_ctrl_i ? '0 : ctrl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign rd_o   = st_q.rd;

endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
    import lui_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int INSTR_W = 32,
    parameter int REG_AW  = 5,
    parameter int PC_STEP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] fetch_word_i,
    output logic [PC_W-1:0]    pc_o,
    output logic               pc_we_o,
    output logic               ifid_we_o,
    output logic               bubble_o,
    output logic [INSTR_W-1:0] ifid_instr_o,
    output logic [CTRL_W-1:0]  idex_ctrl_o,
    output logic [REG_AW-1:0]  idex_rd_o
);

    localparam int FIELDS_W = 3 * REG_AW;
    localparam int CLS_LSB  = INSTR_W - 2;

    logic [INSTR_W-1:0] ifid_instr;
    ctrl_t              dec_ctrl;
    logic [REG_AW-1:0]  dec_rd;
    logic [REG_AW-1:0]  dec_rn;
    logic [REG_AW-1:0]  dec_rm;
    ctrl_t              ex_ctrl;
    logic [REG_AW-1:0]  ex_rd;
    logic               pc_we;
    logic               ifid_we;
    logic               zero_ctrl;

    lui_front #(
        .PC_W    (PC_W),
        .INSTR_W (INSTR_W),
        .PC_STEP (PC_STEP)
    ) u_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .pc_we_i      (pc_we),
        .ifid_we_i    (ifid_we),
        .fetch_word_i (fetch_word_i),
        .pc_o         (pc_o),
        .instr_o      (ifid_instr)
    );

    lui_decode #(
        .REG_AW (REG_AW)
    ) u_decode (
        .cls_i    (ifid_instr[CLS_LSB +: 2]),
        .fields_i (ifid_instr[FIELDS_W-1:0]),
        .ctrl_o   (dec_ctrl),
        .rd_o     (dec_rd),
        .rn_o     (dec_rn),
        .rm_o     (dec_rm)
    );

    lui_hazard #(
        .REG_AW       (REG_AW),
        .SKIP_TOP_REG (1'b1)
    ) u_hazard (
        .ex_mem_rd_i (ex_ctrl.mem_rd),
        .ex_rd_i     (ex_rd),
        .id_rn_i     (dec_rn),
        .id_rm_i     (dec_rm),
        .pc_we_o     (pc_we),
        .ifid_we_o   (ifid_we),
        .ctrl_zero_o (zero_ctrl)
    );

    lui_idex #(
        .REG_AW (REG_AW)
    ) u_idex (
        .clk         (clk),
        .rst_n       (rst_n),
        .zero_ctrl_i (zero_ctrl),
        .ctrl_i      (dec_ctrl),
        .rd_i        (dec_rd),
        .ctrl_o      (ex_ctrl),
        .rd_o        (ex_rd)
    );

    assign pc_we_o      = pc_we;
    assign ifid_we_o    = ifid_we;
    assign bubble_o     = zero_ctrl;
    assign ifid_instr_o = ifid_instr;
    assign idex_ctrl_o  = ex_ctrl;
    assign idex_rd_o    = ex_rd;

endmodule

// File: rtl/lui_checker.sv
module lui_checker #(
    parameter int PC_W    = 32,
    parameter int INSTR_W = 32,
    parameter int REG_AW  = 5,
    parameter int PC_STEP = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    pc_o,
    input logic               pc_we_o,
    input logic               bubble_o,
    input logic [INSTR_W-1:0] ifid_instr_o,
    input logic [3:0]         idex_ctrl_o,
    input logic [REG_AW-1:0]  idex_rd_o
);

    localparam logic [PC_W-1:0]   STEP    = PC_W'(PC_STEP);
    localparam logic [REG_AW-1:0] TOP_REG = {REG_AW{1'b1}};

    assert_hold_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |=> $stable(pc_o));

    assert_hold_ifid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |=> $stable(ifid_instr_o));

    assert_zero_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |=> (idex_ctrl_o == 4'b0000));

    assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |=> !bubble_o);

    assert_top_reg_exempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rd_o == TOP_REG) |-> !bubble_o);

    assert_needs_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !idex_ctrl_o[2] |-> !bubble_o);

    assert_pc_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_o |=> (pc_o == $past(pc_o) + STEP));

endmodule

bind load_use_interlock lui_checker #(
    .PC_W    (PC_W),
    .INSTR_W (INSTR_W),
    .REG_AW  (REG_AW),
    .PC_STEP (PC_STEP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc_o         (pc_o),
    .pc_we_o      (pc_we_o),
    .bubble_o     (bubble_o),
    .ifid_instr_o (ifid_instr_o),
    .idex_ctrl_o  (idex_ctrl_o),
    .idex_rd_o    (idex_rd_o)
);

// File: tb/load_use_interlock_tb.sv
`timescale 1ns/1ps
module load_use_interlock_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_word;
    logic [31:0] pc;
    logic        pc_we;
    logic        ifid_we;
    logic        bubble;
    logic [31:0] ifid_instr;
    logic [3:0]  idex_ctrl;
    logic [4:0]  idex_rd;

    logic [31:0] prog [0:7];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign fetch_word = prog[pc[4:2]];

    load_use_interlock u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_word_i (fetch_word),
        .pc_o         (pc),
        .pc_we_o      (pc_we),
        .ifid_we_o    (ifid_we),
        .bubble_o     (bubble),
        .ifid_instr_o (ifid_instr),
        .idex_ctrl_o  (idex_ctrl),
        .idex_rd_o    (idex_rd)
    );

    function automatic logic [31:0] mk(input logic [1:0] cls, input logic [4:0] rd,
                                       input logic [4:0] rn, input logic [4:0] rm);
        return {cls, 15'd0, rm, rn, rd};
    endfunction

    // Control layout from R9: {reg write, mem read, mem write, ALU use}
    function automatic logic [3:0] ctrl_of(input logic [31:0] w);
        case (w[31:30])
            2'b01:   return 4'b1001;
            2'b10:   return 4'b1100;
            2'b11:   return 4'b0011;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset;
        @(posedge clk);
        #1 rst_n = 1'b0;
        tick();
        tick();
        chk("R1", "pc", pc, 32'h0);
        chk("R1", "ifid", ifid_instr, 32'h0);
        chk("R1", "ctrl", {28'h0, idex_ctrl}, 32'h0);
        chk("R1", "bubble", {31'h0, bubble}, 32'h0);
        rst_n = 1'b1;
    endtask

    // Runs first/second back to back and checks stall behaviour.
    task automatic run_pair(input string req, input logic [31:0] first,
                            input logic [31:0] second, input bit exp_stall);
        for (int i = 0; i < 8; i++) prog[i] = 32'h0;
        prog[0] = first;
        prog[1] = second;
        do_reset();
        tick();
        tick();
        // second instruction in decode, first in execute
        chk(req, "bubble", {31'h0, bubble}, {31'h0, exp_stall});
        chk(req, "pc_we", {31'h0, pc_we}, {31'h0, !exp_stall});
        chk(req, "ifid_we", {31'h0, ifid_we}, {31'h0, !exp_stall});
        tick();
        if (exp_stall) begin
            chk("R6", "pc held", pc, 32'd8);
            chk("R6", "ifid held", ifid_instr, second);
            chk("R7", "ctrl zero", {28'h0, idex_ctrl}, 32'h0);
            chk("R8", "no second bubble", {31'h0, bubble}, 32'h0);
            tick();
            chk("R8", "pc resumes", pc, 32'd12);
            chk("R8", "dep ctrl", {28'h0, idex_ctrl}, {28'h0, ctrl_of(second)});
            chk("R8", "dep rd", {27'h0, idex_rd}, {27'h0, second[4:0]});
        end else begin
            chk("R9", "pc advance", pc, 32'd12);
            chk("R9", "ifid next", ifid_instr, 32'h0);
            chk("R9", "ctrl pass", {28'h0, idex_ctrl}, {28'h0, ctrl_of(second)});
            chk("R9", "rd pass", {27'h0, idex_rd}, {27'h0, second[4:0]});
        end
    endtask

    task automatic test_dep_first;
        run_pair("R2", mk(2'b10, 5'd1, 5'd9, 5'd9), mk(2'b01, 5'd2, 5'd1, 5'd3), 1'b1);
    endtask

    task automatic test_dep_second;
        run_pair("R3", mk(2'b10, 5'd4, 5'd9, 5'd9), mk(2'b01, 5'd5, 5'd6, 5'd4), 1'b1);
    endtask

    task automatic test_store_dep;
        run_pair("R2", mk(2'b10, 5'd7, 5'd8, 5'd8), mk(2'b11, 5'd10, 5'd7, 5'd11), 1'b1);
    endtask

    task automatic test_independent;
        run_pair("R9", mk(2'b10, 5'd1, 5'd9, 5'd9), mk(2'b01, 5'd2, 5'd3, 5'd5), 1'b0);
    endtask

    task automatic test_alu_producer;
        run_pair("R4", mk(2'b01, 5'd1, 5'd2, 5'd3), mk(2'b01, 5'd2, 5'd1, 5'd1), 1'b0);
    endtask

    task automatic test_top_reg;
        run_pair("R5", mk(2'b10, 5'd31, 5'd9, 5'd9), mk(2'b01, 5'd2, 5'd31, 5'd31), 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) prog[i] = 32'h0;
        test_dep_first();
        test_dep_second();
        test_store_dep();
        test_independent();
        test_alu_producer();
        test_top_reg();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule